// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block lets an external controller read and write a small bank of byte-wide configuration registers over three wires: an active-low select, a serial clock and one shared data line. The data line is split at the block edge into an input, an output and an output enable, so a pad cell outside the block can form the bidirectional pin. All three serial signals are sampled in the system clock domain, and the serial clock must run several times slower than the system clock.

A frame opens with a 16-bit instruction that carries a read flag, a two-bit length code and a 13-bit start address. Data bytes follow it. On a read, the block takes over the data line from the first data bit onward. The select line may rise between whole bytes to pause a counted transfer. A rise in the middle of a byte throws the frame away. A bit in register 0 switches the serial bit order from most-significant-first to least-significant-first. The same choice sets the direction in which the working address steps. On-chip logic reads any register through a separate combinational port.

Top module: `spi3_cfg_port`

## Requirements
- R1: After reset, spi_sdo_en is low, every register reads 0 on the core port, and the port uses most-significant-first order.
- R2: A frame starts at the first rising serial clock edge seen while spi_csn is low. Data is sampled on rising edges. A rising edge sampled in a system cycle where spi_csn is high is ignored, as is all clock activity while spi_csn is high.
- R3: In most-significant-first order the instruction arrives as the read flag (1 = read), the length bits L1 then L0, and then address bits A12 down to A0. Data bytes of 8 bits follow.
- R4: Length code {L1,L0} = 00, 01, 10 moves 1, 2 or 3 data bytes. Further clocks in the same frame are ignored and write nothing.
- R5: Length code 11 streams bytes for as long as clocks arrive. A rise of spi_csn at a byte boundary ends the streaming frame.
- R6: On a read, the first data bit is driven and spi_sdo_en rises after the first falling clock edge that follows the 16th rising edge. Each later bit follows its own falling edge. Addresses of REG_DEPTH and above read as 0, and writes to them change nothing.
- R7: Each complete write byte is stored at the working address and shows on core_rdata in the system cycle after the 8th rising edge of that byte.
- R8: After each data byte the working address moves by one, modulo 2^13. It moves down in most-significant-first order and up in least-significant-first order.
- R9: In a counted frame, spi_csn high at a byte boundary pauses the frame, including after the first 8 instruction bits. When spi_csn falls again, the frame resumes. On a read, the next bit is driven again before the next rising edge.
- R10: spi_csn rising in the middle of a byte aborts the frame and commits nothing from the partial byte. The next low period starts a new frame.
- R11: spi_sdo_en is low in every system cycle that follows a cycle in which spi_csn was sampled high.
- R12: Bit 6 of register 0 selects least-significant-first order. The order is latched at the first rising edge of a frame. In that order, the instruction arrives as A0 through A12, then L0, L1 and the read flag, and each data byte arrives with bit 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock |
| spi_sdi | input | 1 | Data line as seen at the pad input |
| spi_sdo | output | 1 | Data line value driven during reads |
| spi_sdo_en | output | 1 | Pad drive enable for the data line |
| core_addr | input | $clog2(REG_DEPTH) | Register index for the on-chip read port |
| core_rdata | output | 8 | Register contents at core_addr |

## Verification
Two events can fall in the same system cycle: the rising serial clock edge that would complete a write byte, and the rise of spi_csn. The bench provokes this by changing both pins at one falling system edge after seven data bits. The correct outcome follows from the rule that an edge seen with select high is ignored. The byte is therefore partial and aborted, so the target register must still hold its old value on the core port. A behavioural register model and a per-cycle monitor on the drive enable check every transfer around that collision.

// File: rtl/spi3_pkg.sv
package spi3_pkg;

    localparam int INSTR_BITS   = 16;
    localparam int ADDR_BITS    = 13;
    localparam int BYTE_BITS    = 8;
    localparam int CFG_REG_IDX  = 0;
    localparam int LSB_CFG_BIT  = 6;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_INSTR = 2'd1,
        FR_DATA  = 2'd2,
        FR_DONE  = 2'd3
    } frame_state_e;

    typedef enum logic [1:0] {
        LEN_ONE    = 2'b00,
        LEN_TWO    = 2'b01,
        LEN_THREE  = 2'b10,
        LEN_STREAM = 2'b11
    } len_code_e;

    typedef struct packed {
        logic                 rd;
        len_code_e            len;
        logic [ADDR_BITS-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic                 en;
        logic [ADDR_BITS-1:0] addr;
        logic [BYTE_BITS-1:0] data;
    } wr_req_t;

    function automatic logic [INSTR_BITS-1:0] flip16(input logic [INSTR_BITS-1:0] v);
        logic [INSTR_BITS-1:0] r;
        for (int i = 0; i < INSTR_BITS; i++) r[i] = v[INSTR_BITS-1-i];
        return r;
    endfunction

    function automatic logic [BYTE_BITS-1:0] flip8(input logic [BYTE_BITS-1:0] v);
        logic [BYTE_BITS-1:0] r;
        for (int i = 0; i < BYTE_BITS; i++) r[i] = v[BYTE_BITS-1-i];
        return r;
    endfunction

    function automatic logic [1:0] len_bytes(input len_code_e c);
        case (c)
            LEN_ONE:   return 2'd1;
            LEN_TWO:   return 2'd2;
            LEN_THREE: return 2'd3;
            default:   return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/spi3_pin_sense.sv
module spi3_pin_sense (
    input  logic clk,
    input  logic rst,
    input  logic csn_i,
    input  logic sclk_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic csn_fall_o
);

    logic sclk_q;
    logic csn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_i;
            csn_q  <= csn_i;
        end
    end

    // Clock edges only count while the select is low in the same cycle.
    assign sclk_rise_o = sclk_i & ~sclk_q & ~csn_i;
    assign sclk_fall_o = ~sclk_i & sclk_q & ~csn_i;
    assign csn_fall_o  = ~csn_i & csn_q;

    p_edge_gate_r2: assert property (@(posedge clk) disable iff (rst)
        csn_i |-> !(sclk_rise_o || sclk_fall_o));

endmodule

// File: rtl/spi3_regbank.sv
module spi3_regbank
    import spi3_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wr_req_t              wr_i,
    input  logic [ADDR_BITS-1:0] rd_addr_i,
    output logic [BYTE_BITS-1:0] rd_data_o,
    input  logic [IDX_W-1:0]     core_addr_i,
    output logic [BYTE_BITS-1:0] core_data_o,
    output logic                 cfg_lsb_o
);

    logic [DEPTH-1:0][BYTE_BITS-1:0] regs;
    logic [DEPTH-1:0]                hit;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_hit
            assign hit[g] = wr_i.en && (wr_i.addr == ADDR_BITS'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i]) regs[i] <= wr_i.data;
            end
        end
    end

    assign rd_data_o   = (32'(rd_addr_i) < DEPTH) ? regs[rd_addr_i[IDX_W-1:0]] : '0;
    assign core_data_o = (32'(core_addr_i) < DEPTH) ? regs[core_addr_i] : '0;
    assign cfg_lsb_o   = regs[CFG_REG_IDX][LSB_CFG_BIT];

    p_commit_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && 32'(wr_i.addr) < DEPTH)
        |=> regs[$past(wr_i.addr[IDX_W-1:0])] == $past(wr_i.data));

    p_oob_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && 32'(wr_i.addr) >= DEPTH) |=> $stable(regs));

endmodule

// File: rtl/spi3_framer.sv
module spi3_framer
    import spi3_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 csn_i,
    input  logic                 sclk_rise_i,
    input  logic                 sclk_fall_i,
    input  logic                 csn_fall_i,
    input  logic                 sdi_i,
    input  logic                 cfg_lsb_i,
    input  logic [BYTE_BITS-1:0] rd_data_i,
    output logic [ADDR_BITS-1:0] rd_addr_o,
    output wr_req_t              wr_o,
    output logic                 sdo_o,
    output logic                 sdo_en_o
);

    localparam logic [3:0] LAST_INSTR_BIT = 4'(INSTR_BITS - 1);

    frame_state_e          state_q;
    logic [3:0]            cnt_q;
    logic [INSTR_BITS-1:0] shreg_q;
    logic                  lsb_q;
    logic                  rd_q;
    logic                  stream_q;
    logic [1:0]            left_q;
    logic [ADDR_BITS-1:0]  addr_q;
    logic                  sdo_q;
    logic                  oe_q;

    logic [INSTR_BITS-1:0] shift_next;
    instr_t                instr_now;
    logic [BYTE_BITS-1:0]  byte_now;
    logic                  byte_end;
    logic                  at_boundary;
    logic [ADDR_BITS-1:0]  addr_step;
    logic [2:0]            bit_sel;

    always_comb begin
        shift_next  = {shreg_q[INSTR_BITS-2:0], sdi_i};
        instr_now   = instr_t'(lsb_q ? flip16(shift_next) : shift_next);
        byte_now    = lsb_q ? flip8(shift_next[BYTE_BITS-1:0]) : shift_next[BYTE_BITS-1:0];
        byte_end    = (cnt_q[2:0] == 3'd7);
        at_boundary = (cnt_q[2:0] == 3'd0);
        addr_step   = lsb_q ? addr_q + 13'd1 : addr_q - 13'd1;
        bit_sel     = lsb_q ? cnt_q[2:0] : 3'd7 - cnt_q[2:0];
    end

    always_comb begin
        wr_o.en   = (state_q == FR_DATA) && sclk_rise_i && byte_end && !rd_q;
        wr_o.addr = addr_q;
        wr_o.data = byte_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FR_IDLE;
            cnt_q    <= '0;
            shreg_q  <= '0;
            lsb_q    <= 1'b0;
            rd_q     <= 1'b0;
            stream_q <= 1'b0;
            left_q   <= '0;
            addr_q   <= '0;
            sdo_q    <= 1'b0;
            oe_q     <= 1'b0;
        end else if (csn_i) begin
            oe_q <= 1'b0;
            if (state_q != FR_IDLE) begin
                if (!at_boundary) begin
                    state_q <= FR_IDLE;
                end else if (state_q == FR_DONE || (state_q == FR_DATA && stream_q)) begin
                    state_q <= FR_IDLE;
                end
            end
        end else begin
            if (sclk_rise_i) begin
                unique case (state_q)
                    FR_IDLE: begin
                        shreg_q <= shift_next;
                        cnt_q   <= 4'd1;
                        lsb_q   <= cfg_lsb_i;
                        state_q <= FR_INSTR;
                    end
                    FR_INSTR: begin
                        shreg_q <= shift_next;
                        if (cnt_q == LAST_INSTR_BIT) begin
                            cnt_q    <= '0;
                            state_q  <= FR_DATA;
                            rd_q     <= instr_now.rd;
                            stream_q <= (instr_now.len == LEN_STREAM);
                            left_q   <= len_bytes(instr_now.len);
                            addr_q   <= instr_now.addr;
                        end else begin
                            cnt_q <= cnt_q + 4'd1;
                        end
                    end
                    FR_DATA: begin
                        shreg_q <= shift_next;
                        if (byte_end) begin
                            cnt_q  <= '0;
                            addr_q <= addr_step;
                            if (!stream_q) begin
                                left_q <= left_q - 2'd1;
                                if (left_q == 2'd1) state_q <= FR_DONE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
            if (sclk_fall_i || csn_fall_i) begin
                if (state_q == FR_DATA && rd_q) begin
                    sdo_q <= rd_data_i[bit_sel];
                    oe_q  <= 1'b1;
                end else begin
                    oe_q  <= 1'b0;
                end
            end
        end
    end

    assign rd_addr_o = addr_q;
    assign sdo_o     = sdo_q;
    assign sdo_en_o  = oe_q;

    p_release_r11: assert property (@(posedge clk) disable iff (rst)
        csn_i |=> !sdo_en_o);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == FR_IDLE && csn_i) |=> state_q == FR_IDLE);

    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (csn_i && state_q != FR_IDLE && cnt_q[2:0] != 3'd0) |=> state_q == FR_IDLE);

    p_stall_instr_r9: assert property (@(posedge clk) disable iff (rst)
        (csn_i && state_q == FR_INSTR && cnt_q[2:0] == 3'd0)
        |=> (state_q == FR_INSTR && $stable(shreg_q)));

    p_drive_read_r6: assert property (@(posedge clk) disable iff (rst)
        sdo_en_o |-> (rd_q && state_q != FR_IDLE));

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == FR_DATA && sclk_rise_i && cnt_q[2:0] == 3'd7)
        |=> addr_q == ($past(lsb_q) ? $past(addr_q) + 13'd1 : $past(addr_q) - 13'd1));

endmodule

// File: rtl/spi3_cfg_port.sv
module spi3_cfg_port
    import spi3_pkg::*;
#(
    parameter int REG_DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         spi_csn,
    input  logic                         spi_sclk,
    input  logic                         spi_sdi,
    output logic                         spi_sdo,
    output logic                         spi_sdo_en,
    input  logic [$clog2(REG_DEPTH)-1:0] core_addr,
    output logic [BYTE_BITS-1:0]         core_rdata
);

    logic                 sclk_rise;
    logic                 sclk_fall;
    logic                 csn_fall;
    logic                 cfg_lsb;
    logic [ADDR_BITS-1:0] rd_addr;
    logic [BYTE_BITS-1:0] rd_data;
    wr_req_t              wr_req;

    spi3_pin_sense i_sense (
        .clk         (clk),
        .rst         (rst),
        .csn_i       (spi_csn),
        .sclk_i      (spi_sclk),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .csn_fall_o  (csn_fall)
    );

    spi3_framer i_framer (
        .clk         (clk),
        .rst         (rst),
        .csn_i       (spi_csn),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .csn_fall_i  (csn_fall),
        .sdi_i       (spi_sdi),
        .cfg_lsb_i   (cfg_lsb),
        .rd_data_i   (rd_data),
        .rd_addr_o   (rd_addr),
        .wr_o        (wr_req),
        .sdo_o       (spi_sdo),
        .sdo_en_o    (spi_sdo_en)
    );

    spi3_regbank #(.DEPTH(REG_DEPTH)) i_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (wr_req),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .core_addr_i (core_addr),
        .core_data_o (core_rdata),
        .cfg_lsb_o   (cfg_lsb)
    );

endmodule

// File: tb/test_spi3_cfg_port.sv
`timescale 1ns/1ps
module test_spi3_cfg_port;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csn = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       sdo_en;
    logic [3:0] core_addr = '0;
    logic [7:0] core_rdata;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] mreg [DEPTH];
    bit         mon_on = 1'b0;
    logic       cs_at_edge = 1'b0;

    always #2.5 clk = ~clk;

    spi3_cfg_port #(.REG_DEPTH(DEPTH)) i_spi3_cfg_port (
        .clk        (clk),
        .rst        (rst),
        .spi_csn    (csn),
        .spi_sclk   (sclk),
        .spi_sdi    (sdi),
        .spi_sdo    (sdo),
        .spi_sdo_en (sdo_en),
        .core_addr  (core_addr),
        .core_rdata (core_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Per-cycle reference: the drive enable follows the sampled select.
    always @(posedge clk) cs_at_edge <= csn;
    always @(negedge clk) begin
        if (mon_on && cs_at_edge) chk(sdo_en == 1'b0, "R11 enable after select high", int'(sdo_en), 0);
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        report();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic so, output logic oe);
        sclk = 1'b0;
        sdi  = b;
        tick(2);
        so = sdo;
        oe = sdo_en;
        sclk = 1'b1;
        tick(2);
    endtask

    task automatic cs_low();
        csn = 1'b0;
        sclk = 1'b0;
        tick(2);
    endtask

    task automatic cs_high(input int n);
        csn = 1'b1;
        sclk = 1'b0;
        tick(n);
    endtask

    function automatic logic [15:0] mk_instr(input bit rd, input logic [1:0] len, input logic [12:0] a);
        return {rd, len, a};
    endfunction

    task automatic send_instr_bits(input logic [15:0] w, input bit lsb, input int from, input int upto);
        logic so, oe;
        for (int i = from; i < upto; i++) spi_bit(lsb ? w[i] : w[15-i], so, oe);
    endtask

    task automatic xfer_byte(input logic [7:0] wd, input bit lsb, output logic [7:0] rd, output bit oe_all);
        logic so, oe;
        oe_all = 1'b1;
        rd = '0;
        for (int i = 0; i < 8; i++) begin
            int idx = lsb ? i : 7 - i;
            spi_bit(wd[idx], so, oe);
            rd[idx] = so;
            oe_all = oe_all & oe;
        end
    endtask

    function automatic logic [12:0] step(input logic [12:0] a, input bit lsb);
        return lsb ? a + 13'd1 : a - 13'd1;
    endfunction

    function automatic logic [7:0] mread(input logic [12:0] a);
        return (a < 13'(DEPTH)) ? mreg[a[3:0]] : 8'h00;
    endfunction

    task automatic mwrite(input logic [12:0] a, input logic [7:0] d);
        if (a < 13'(DEPTH)) mreg[a[3:0]] = d;
    endtask

    task automatic frame_write(input logic [12:0] a0, input logic [1:0] len,
                               input logic [7:0] d [4], input int n, input bit lsb);
        logic [7:0] rb;
        bit oa;
        logic [12:0] a = a0;
        cs_low();
        send_instr_bits(mk_instr(1'b0, len, a0), lsb, 0, 16);
        for (int i = 0; i < n; i++) begin
            xfer_byte(d[i], lsb, rb, oa);
            mwrite(a, d[i]);
            a = step(a, lsb);
        end
        cs_high(4);
    endtask

    task automatic frame_read(input logic [12:0] a0, input logic [1:0] len, input int n,
                              input bit lsb, input string req);
        logic [7:0] rb;
        bit oa;
        logic [12:0] a = a0;
        cs_low();
        send_instr_bits(mk_instr(1'b1, len, a0), lsb, 0, 16);
        for (int i = 0; i < n; i++) begin
            xfer_byte(8'h00, lsb, rb, oa);
            chk(rb == mread(a), req, int'(rb), int'(mread(a)));
            chk(oa == 1'b1, {req, " drive enable"}, int'(oa), 1);
            a = step(a, lsb);
        end
        cs_high(4);
    endtask

    task automatic core_check(input int idx, input string req);
        core_addr = 4'(idx);
        tick(1);
        chk(core_rdata == mreg[idx], req, int'(core_rdata), int'(mreg[idx]));
    endtask

    initial begin
        logic [7:0] rb;
        logic so, oe;
        bit oa;
        for (int i = 0; i < DEPTH; i++) mreg[i] = 8'h00;
        tick(4);
        rst = 1'b0;
        tick(2);
        mon_on = 1'b1;

        // R1 reset state
        chk(sdo_en == 1'b0, "R1 enable after reset", int'(sdo_en), 0);
        core_check(0, "R1 register 0 after reset");
        core_check(9, "R1 register 9 after reset");

        // R3 R7 single byte write, MSB order
        frame_write(13'd5, 2'b00, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1, 1'b0);
        core_check(5, "R7 single write");

        // R4 R8 three bytes downward, extra byte ignored
        cs_low();
        send_instr_bits(mk_instr(1'b0, 2'b10, 13'd9), 1'b0, 0, 16);
        xfer_byte(8'h11, 1'b0, rb, oa); mwrite(13'd9, 8'h11);
        xfer_byte(8'h22, 1'b0, rb, oa); mwrite(13'd8, 8'h22);
        xfer_byte(8'h33, 1'b0, rb, oa); mwrite(13'd7, 8'h33);
        xfer_byte(8'hFF, 1'b0, rb, oa);
        cs_high(4);
        core_check(9, "R8 first byte at start address");
        core_check(7, "R8 third byte two below start");
        core_check(6, "R4 byte beyond length ignored");

        // R6 two byte read
        frame_read(13'd9, 2'b01, 2, 1'b0, "R6 read two bytes");

        // R5 streaming write and read
        frame_write(13'd4, 2'b11, '{8'h44, 8'h43, 8'h42, 8'h41}, 4, 1'b0);
        core_check(1, "R5 fourth streamed byte");
        frame_read(13'd4, 2'b11, 4, 1'b0, "R5 streaming read");

        // R9 stall inside instruction and between write bytes
        cs_low();
        send_instr_bits(mk_instr(1'b0, 2'b01, 13'd12), 1'b0, 0, 8);
        cs_high(6);
        cs_low();
        send_instr_bits(mk_instr(1'b0, 2'b01, 13'd12), 1'b0, 8, 16);
        xfer_byte(8'hC1, 1'b0, rb, oa); mwrite(13'd12, 8'hC1);
        cs_high(6);
        cs_low();
        xfer_byte(8'hC2, 1'b0, rb, oa); mwrite(13'd11, 8'hC2);
        cs_high(4);
        core_check(12, "R9 byte before pause");
        core_check(11, "R9 byte after pause");

        // R9 stall inside a read
        cs_low();
        send_instr_bits(mk_instr(1'b1, 2'b01, 13'd9), 1'b0, 0, 16);
        xfer_byte(8'h00, 1'b0, rb, oa);
        chk(rb == 8'h11, "R9 read before pause", int'(rb), 8'h11);
        cs_high(6);
        cs_low();
        xfer_byte(8'h00, 1'b0, rb, oa);
        chk(rb == 8'h22, "R9 read after pause", int'(rb), 8'h22);
        chk(oa == 1'b1, "R9 enable after resume", int'(oa), 1);
        cs_high(4);

        // R10 mid-byte abort
        cs_low();
        send_instr_bits(mk_instr(1'b0, 2'b00, 13'd13), 1'b0, 0, 16);
        for (int i = 0; i < 4; i++) spi_bit(1'b1, so, oe);
        cs_high(6);
        core_check(13, "R10 partial byte not written");

        // R2 eighth edge together with select rise
        cs_low();
        send_instr_bits(mk_instr(1'b0, 2'b00, 13'd13), 1'b0, 0, 16);
        for (int i = 0; i < 7; i++) spi_bit(1'b1, so, oe);
        sclk = 1'b0;
        tick(2);
        csn  = 1'b1;
        sclk = 1'b1;
        tick(3);
        sclk = 1'b0;
        tick(3);
        core_check(13, "R2 edge with select high ignored");

        // R2 clocks with select high, then a clean frame
        sdi = 1'b1;
        for (int i = 0; i < 6; i++) begin
            sclk = ~sclk;
            tick(2);
        end
        sclk = 1'b0;
        tick(2);
        chk(sdo_en == 1'b0, "R2 idle line released", int'(sdo_en), 0);
        frame_read(13'd5, 2'b00, 1, 1'b0, "R2 frame after ignored clocks");

        // R6 out of range
        frame_write(13'h1F00, 2'b00, '{8'h99, 8'h00, 8'h00, 8'h00}, 1, 1'b0);
        core_check(0, "R6 out of range write ignored");
        frame_read(13'h1F00, 2'b00, 1, 1'b0, "R6 out of range reads zero");

        // R12 switch to LSB order, stepping upward
        frame_write(13'd0, 2'b00, '{8'h40, 8'h00, 8'h00, 8'h00}, 1, 1'b0);
        core_check(0, "R12 config written");
        frame_write(13'd2, 2'b01, '{8'h81, 8'h7E, 8'h00, 8'h00}, 2, 1'b1);
        core_check(2, "R12 first LSB byte");
        core_check(3, "R12 second LSB byte upward");
        frame_read(13'd2, 2'b01, 2, 1'b1, "R12 LSB read");

        tick(4);
        report();
    end

endmodule